// File: doc/BRIEF.md
# Dual-Master Bus Ownership Register

Two upstream bus masters, A and B, share a single downstream bus. This block holds the control state that decides which of them owns the downstream channel and whether the upstream and downstream sides are connected. Each master reads and writes its own view of a small control field. In that view the master's own ownership and enable bits are writable. Next to them sit read-only mirrors of the other master's matching bits, so one read tells a master everything it needs about the bus.

Ownership follows a parity handshake, not a request/grant arbiter. A master has the bus when its ownership bit equals the mirrored bit next to it. It takes the bus by writing its own bit to match that mirror. The connection works the same way: the bus is on when a master's enable bit differs from its mirrored enable bit. The block drives a one-hot channel select and a connect enable, both registered, for the switching logic downstream.

A serial front end sits in front of the block. It presents each access as a command byte plus a data byte. Only commands that match the control-register pattern take effect. The bits above the four control bits are plain storage that belongs to each master.

Top module: `bus_owner_reg`

## Requirements
- R1: A matching read (req=1, we=0) returns the master's view on `*_rdata` in the next cycle. Bit 0 is own-ownership, bit 1 is mirrored ownership, bit 2 is own-enable, bit 3 is mirrored enable, and bits DATA_W-1:4 are the master's own stored upper bits. In every other cycle `*_rdata` is 0.
- R2: A owns the bus when A's and B's ownership bits are equal, and B owns it when they differ. A's mirrored ownership bit equals B's ownership bit. B's mirrored ownership bit is the inverse of A's ownership bit. So each view shows control exactly when bit 0 equals bit 1. `chan_sel` is one-hot: bit 0 selects A and bit 1 selects B.
- R3: `bus_connect` is 1 exactly when A's and B's enable bits differ. Each view's bit 3 shows the other master's enable bit without change.
- R4: Write data in bit positions 3 and 1 is ignored. Those view bits keep showing the other master's state.
- R5: A matching write (req=1, we=1) updates the master's own bits 0 and 2 and its upper bits at the next clock edge. `chan_sel` and `bus_connect` show the result from that same edge. A master takes ownership by writing bit 0 equal to its read bit 1, and gives it up by writing the opposite value.
- R6: An access takes effect only when the command byte matches 000x0001, that is, bits 7:5 are 0 and bits 3:0 are 0001, with bit 4 free. A write with any other command changes nothing. A read with any other command returns 0.
- R7: After reset, all stored bits are 0. `chan_sel` is 2'b01 (A owns), `bus_connect` is 0, A reads 0x00 and B reads 0x02.
- R8: When both masters write in the same cycle, A's write is applied first. B's written bits are then judged against the A values that B read. B's new ownership bit is its written bit XOR A's old bit XOR A's new bit, and the enable bit follows the same rule. As a result, a take by B always ends with `chan_sel` = 2'b10.
- R9: If a master writes back the own-bit values it just read, ownership, connection and both views stay the same.
- R10: The upper bits of each master are independent storage. They are written only by that master's matching writes and read back only in its own view.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_req | input | 1 | Master A access strobe |
| a_we | input | 1 | Master A write (1) / read (0) |
| a_cmd | input | CMD_W | Master A command byte |
| a_wdata | input | DATA_W | Master A write data |
| a_rdata | output | DATA_W | Master A read view, registered |
| b_req | input | 1 | Master B access strobe |
| b_we | input | 1 | Master B write (1) / read (0) |
| b_cmd | input | CMD_W | Master B command byte |
| b_wdata | input | DATA_W | Master B write data |
| b_rdata | output | DATA_W | Master B read view, registered |
| chan_sel | output | 2 | One-hot owner select, bit 0 = A, bit 1 = B |
| bus_connect | output | 1 | Upstream-downstream connect enable |

## Verification
The bench builds the block with its defaults: an 8-bit data word, an 8-bit command, match value 0x01 and bit 4 as the don't-care bit. With these values the bench can show that commands 0x01 and 0x11 are accepted and that neighbours differing in a fixed bit are rejected. The four upper bits are wide enough to show per-master storage that does not leak across. The bench drives ownership through every parity combination, including both masters writing in the same cycle from either owner.

// File: rtl/bor_pkg.sv
package bor_pkg;
  localparam int CTL_W  = 4;
  localparam int N_MST  = 2;
  localparam int IDX_A  = 0;
  localparam int IDX_B  = 1;

  // Low-bit layout of a master's view; position matters to software.
  typedef struct packed {
    logic peer_en;   // bit 3: mirrored enable
    logic own_en;    // bit 2: own enable
    logic peer_own;  // bit 1: mirrored ownership
    logic own_bit;   // bit 0: own ownership
  } ctl_view_t;
endpackage

// File: rtl/bor_cmd_match.sv
module bor_cmd_match #(
  parameter int               CMD_W     = 8,
  parameter logic [CMD_W-1:0] MATCH     = 'h01,
  parameter logic [CMD_W-1:0] DONT_CARE = 'h10
) (
  input  logic [CMD_W-1:0] cmd,
  output logic             hit
);
  localparam logic [CMD_W-1:0] CARE = ~DONT_CARE;

  always_comb begin
    hit = (((cmd ^ MATCH) & CARE) == '0);
  end
endmodule

// File: rtl/bor_state.sv
module bor_state #(
  parameter int UP_W = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [bor_pkg::N_MST-1:0]           wr,
  input  logic [bor_pkg::N_MST-1:0]           wd_own,
  input  logic [bor_pkg::N_MST-1:0]           wd_en,
  input  logic [bor_pkg::N_MST-1:0][UP_W-1:0] wd_up,
  output logic [bor_pkg::N_MST-1:0]           own_q,
  output logic [bor_pkg::N_MST-1:0]           en_q,
  output logic [bor_pkg::N_MST-1:0][UP_W-1:0] up_q,
  output logic [bor_pkg::N_MST-1:0]           own_d,
  output logic [bor_pkg::N_MST-1:0]           en_d
);
  import bor_pkg::*;

  // A's write lands first; B's write is taken relative to the A bits
  // it observed, rebased onto A's new bits.
  always_comb begin
    own_d[IDX_A] = wr[IDX_A] ? wd_own[IDX_A] : own_q[IDX_A];
    en_d[IDX_A]  = wr[IDX_A] ? wd_en[IDX_A]  : en_q[IDX_A];
    own_d[IDX_B] = wr[IDX_B] ? (wd_own[IDX_B] ^ own_q[IDX_A] ^ own_d[IDX_A])
                             : own_q[IDX_B];
    en_d[IDX_B]  = wr[IDX_B] ? (wd_en[IDX_B] ^ en_q[IDX_A] ^ en_d[IDX_A])
                             : en_q[IDX_B];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q <= '0;
      en_q  <= '0;
    end else begin
      own_q <= own_d;
      en_q  <= en_d;
    end
  end

  for (genvar g = 0; g < N_MST; g++) begin : g_up
    always_ff @(posedge clk) begin
      if (rst)
        up_q[g] <= '0;
      else if (wr[g])
        up_q[g] <= wd_up[g];
    end
  end
endmodule

// File: rtl/bor_eval.sv
module bor_eval (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [bor_pkg::N_MST-1:0] own_d,
  input  logic [bor_pkg::N_MST-1:0] en_d,
  output logic [bor_pkg::N_MST-1:0] sel,
  output logic                      connect
);
  import bor_pkg::*;

  logic b_owns;
  logic link_on;

  always_comb begin
    b_owns  = own_d[IDX_A] ^ own_d[IDX_B];
    link_on = en_d[IDX_A] ^ en_d[IDX_B];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel     <= 2'b01;
      connect <= 1'b0;
    end else begin
      sel     <= {b_owns, ~b_owns};
      connect <= link_on;
    end
  end
endmodule

// File: rtl/bor_view.sv
module bor_view #(
  parameter int DATA_W     = 8,
  parameter bit MIRROR_INV = 1'b0
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             rd_en,
  input  logic                             own_bit,
  input  logic                             own_en,
  input  logic                             peer_bit,
  input  logic                             peer_en,
  input  logic [DATA_W-bor_pkg::CTL_W-1:0] up,
  output logic [DATA_W-1:0]                rdata
);
  import bor_pkg::*;

  ctl_view_t view;

  always_comb begin
    view.peer_en  = peer_en;
    view.own_en   = own_en;
    view.peer_own = peer_bit ^ MIRROR_INV;
    view.own_bit  = own_bit;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en)
      rdata <= {up, view};
    else
      rdata <= '0;
  end
endmodule

// File: rtl/bus_owner_reg.sv
module bus_owner_reg #(
  parameter int               DATA_W     = 8,
  parameter int               CMD_W      = 8,
  parameter logic [CMD_W-1:0] CMD_MATCH  = 'h01,
  parameter logic [CMD_W-1:0] CMD_IGNORE = 'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_req,
  input  logic              a_we,
  input  logic [CMD_W-1:0]  a_cmd,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_req,
  input  logic              b_we,
  input  logic [CMD_W-1:0]  b_cmd,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic [1:0]        chan_sel,
  output logic              bus_connect
);
  import bor_pkg::*;

  localparam int UP_W = DATA_W - CTL_W;

  logic [N_MST-1:0]             req_v, we_v, hit_v, wr_v, rd_v;
  logic [N_MST-1:0][CMD_W-1:0]  cmd_v;
  logic [N_MST-1:0][DATA_W-1:0] wd_v, rdat_v;
  logic [N_MST-1:0]             wd_own, wd_en;
  logic [N_MST-1:0][UP_W-1:0]   wd_up, up_q;
  logic [N_MST-1:0]             own_q, en_q, own_d, en_d;
  logic                         a_wr_ok, b_wr_ok;

  assign req_v = {b_req, a_req};
  assign we_v  = {b_we, a_we};
  assign cmd_v = {b_cmd, a_cmd};
  assign wd_v  = {b_wdata, a_wdata};
  assign a_rdata = rdat_v[IDX_A];
  assign b_rdata = rdat_v[IDX_B];
  assign a_wr_ok = wr_v[IDX_A];
  assign b_wr_ok = wr_v[IDX_B];

  for (genvar g = 0; g < N_MST; g++) begin : g_mst
    bor_cmd_match #(
      .CMD_W    (CMD_W),
      .MATCH    (CMD_MATCH),
      .DONT_CARE(CMD_IGNORE)
    ) u_match (
      .cmd(cmd_v[g]),
      .hit(hit_v[g])
    );

    assign wr_v[g]   = req_v[g] &  we_v[g] & hit_v[g];
    assign rd_v[g]   = req_v[g] & ~we_v[g] & hit_v[g];
    assign wd_own[g] = wd_v[g][0];
    assign wd_en[g]  = wd_v[g][2];
    assign wd_up[g]  = wd_v[g][DATA_W-1:CTL_W];

    bor_view #(
      .DATA_W    (DATA_W),
      .MIRROR_INV(g == IDX_B)
    ) u_view (
      .clk     (clk),
      .rst     (rst),
      .rd_en   (rd_v[g]),
      .own_bit (own_q[g]),
      .own_en  (en_q[g]),
      .peer_bit(own_q[N_MST-1-g]),
      .peer_en (en_q[N_MST-1-g]),
      .up      (up_q[g]),
      .rdata   (rdat_v[g])
    );
  end

  bor_state #(.UP_W(UP_W)) u_state (
    .clk   (clk),
    .rst   (rst),
    .wr    (wr_v),
    .wd_own(wd_own),
    .wd_en (wd_en),
    .wd_up (wd_up),
    .own_q (own_q),
    .en_q  (en_q),
    .up_q  (up_q),
    .own_d (own_d),
    .en_d  (en_d)
  );

  bor_eval u_eval (
    .clk    (clk),
    .rst    (rst),
    .own_d  (own_d),
    .en_d   (en_d),
    .sel    (chan_sel),
    .connect(bus_connect)
  );
endmodule

// File: rtl/bor_checker.sv
module bor_checker (
  input logic       clk,
  input logic       rst,
  input logic       wr_a,
  input logic       wr_b,
  input logic       a_wbit,
  input logic       b_wbit,
  input logic [1:0] own_q,
  input logic [1:0] en_q,
  input logic [1:0] chan_sel,
  input logic       bus_connect
);
  // R2: exactly one owner at all times
  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot(chan_sel));

  // R2: select follows parity of the stored ownership bits
  p_owner_parity_r2: assert property (@(posedge clk) disable iff (rst)
    chan_sel[0] == (own_q[0] == own_q[1]));

  // R3: connect follows inequality of the stored enable bits
  p_connect_r3: assert property (@(posedge clk) disable iff (rst)
    bus_connect == (en_q[0] != en_q[1]));

  // R6: no accepted write means outputs hold
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!wr_a && !wr_b) |=> ($stable(chan_sel) && $stable(bus_connect)));

  // R7: reset leaves A as owner with the link off
  p_reset_state_r7: assert property (@(posedge clk)
    rst |=> (chan_sel == 2'b01 && !bus_connect));

  // R5: a lone take by A hands A the bus
  p_a_take_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_a && !wr_b && (a_wbit == own_q[1])) |=> (chan_sel == 2'b01));

  // R8: a take by B during a simultaneous write wins
  p_b_prevails_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_a && wr_b && (b_wbit != own_q[0])) |=> (chan_sel == 2'b10));
endmodule

bind bus_owner_reg bor_checker u_bor_checker (
  .clk        (clk),
  .rst        (rst),
  .wr_a       (a_wr_ok),
  .wr_b       (b_wr_ok),
  .a_wbit     (a_wdata[0]),
  .b_wbit     (b_wdata[0]),
  .own_q      (own_q),
  .en_q       (en_q),
  .chan_sel   (chan_sel),
  .bus_connect(bus_connect)
);

// File: tb/bus_owner_reg_bench.sv
module bus_owner_reg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_req = 0, a_we = 0, b_req = 0, b_we = 0;
  logic [CW-1:0] a_cmd = '0, b_cmd = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic [1:0] chan_sel;
  logic bus_connect;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model of the stored bits
  bit mA, oA, mB, oB;
  bit [3:0] upA, upB;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_owner_reg u_bus_owner_reg (
    .clk(clk), .rst(rst),
    .a_req(a_req), .a_we(a_we), .a_cmd(a_cmd), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_req(b_req), .b_we(b_we), .b_cmd(b_cmd), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .chan_sel(chan_sel), .bus_connect(bus_connect)
  );

  function automatic bit cmd_ok(input logic [7:0] c);
    return (c[7:5] == 3'b000) && (c[3:0] == 4'b0001);
  endfunction

  function automatic logic [7:0] view_of(input bit m);
    if (!m) return {upA, oB, oA, mB, mA};
    return {upB, oA, oB, ~mA, mB};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr1(input bit m, input logic [7:0] c, input logic [7:0] d);
    @(negedge clk);
    if (!m) begin a_req = 1; a_we = 1; a_cmd = c; a_wdata = d; end
    else    begin b_req = 1; b_we = 1; b_cmd = c; b_wdata = d; end
    @(negedge clk);
    a_req = 0; a_we = 0; b_req = 0; b_we = 0;
    if (cmd_ok(c)) begin
      if (!m) begin mA = d[0]; oA = d[2]; upA = d[7:4]; end
      else    begin mB = d[0]; oB = d[2]; upB = d[7:4]; end
    end
  endtask

  task automatic wr2(input logic [7:0] da, input logic [7:0] db);
    bit pm, po;
    @(negedge clk);
    a_req = 1; a_we = 1; a_cmd = 8'h01; a_wdata = da;
    b_req = 1; b_we = 1; b_cmd = 8'h11; b_wdata = db;
    @(negedge clk);
    a_req = 0; a_we = 0; b_req = 0; b_we = 0;
    pm = mA; po = oA;
    mA = da[0]; oA = da[2]; upA = da[7:4];
    mB = db[0] ^ pm ^ mA; oB = db[2] ^ po ^ oA; upB = db[7:4];
  endtask

  task automatic rd(input bit m, input logic [7:0] c, output logic [7:0] v);
    @(negedge clk);
    if (!m) begin a_req = 1; a_we = 0; a_cmd = c; end
    else    begin b_req = 1; b_we = 0; b_cmd = c; end
    @(negedge clk);
    a_req = 0; b_req = 0;
    v = m ? b_rdata : a_rdata;
  endtask

  task automatic check_state(input string req);
    logic [7:0] v;
    chk(req, "chan_sel", {30'd0, chan_sel}, {30'd0, (mA ^ mB), ~(mA ^ mB)});
    chk(req, "bus_connect", {31'd0, bus_connect}, {31'd0, oA ^ oB});
    rd(1'b0, 8'h01, v);
    chk(req, "A view", {24'd0, v}, {24'd0, view_of(1'b0)});
    rd(1'b1, 8'h01, v);
    chk(req, "B view", {24'd0, v}, {24'd0, view_of(1'b1)});
  endtask

  task automatic t_reset;
    chk("R7", "chan_sel", {30'd0, chan_sel}, 32'h1);
    chk("R7", "bus_connect", {31'd0, bus_connect}, 32'h0);
    chk("R1", "idle a_rdata", {24'd0, a_rdata}, 32'h0);
    check_state("R7");
    chk("R7", "B view literal", {24'd0, view_of(1'b1)}, 32'h02);
  endtask

  task automatic t_readonly_bits;
    wr1(1'b0, 8'h01, 8'h0A);   // bits 3 and 1 set, own bits clear
    check_state("R4");
    chk("R4", "A view low", {28'd0, view_of(1'b0)[3:0]}, 32'h0);
  endtask

  task automatic t_b_takes;
    wr1(1'b1, 8'h01, 8'h05);   // B: own=1 matches mirror, enable on
    check_state("R5");
    chk("R5", "B owns", {30'd0, chan_sel}, 32'h2);
    chk("R3", "connected", {31'd0, bus_connect}, 32'h1);
  endtask

  task automatic t_a_takes;
    wr1(1'b0, 8'h01, 8'h01);   // A reads 0xA, writes 1 to take
    check_state("R2");
    chk("R2", "A owns", {30'd0, chan_sel}, 32'h1);
  endtask

  task automatic t_no_change;
    logic [7:0] v;
    rd(1'b0, 8'h01, v);
    wr1(1'b0, 8'h01, v);
    check_state("R9");
  endtask

  task automatic t_cmd_decode;
    logic [7:0] v;
    wr1(1'b0, 8'h03, 8'h04);
    wr1(1'b0, 8'h81, 8'h04);
    wr1(1'b0, 8'h21, 8'h04);
    check_state("R6");
    rd(1'b0, 8'h41, v);
    chk("R6", "bad-cmd read", {24'd0, v}, 32'h0);
    wr1(1'b0, 8'h11, 8'h04);   // don't-care bit set: accepted
    check_state("R6");
  endtask

  task automatic t_upper;
    wr1(1'b0, 8'h01, {4'hB, 1'b0, oA, 1'b0, mA});
    check_state("R10");
    chk("R10", "B upper", {28'd0, view_of(1'b1)[7:4]}, 32'h0);
    wr1(1'b1, 8'h01, {4'h6, 1'b0, oB, 1'b0, mB});
    check_state("R10");
  endtask

  task automatic t_release;
    wr1(1'b0, 8'h01, {upA, 1'b0, oA, 1'b0, ~mB});
    check_state("R5");
    chk("R5", "released to B", {30'd0, chan_sel}, 32'h2);
  endtask

  task automatic t_simultaneous;
    // from B owning: A takes, B keeps its own bit
    wr2({upA, 1'b0, oA, 1'b0, mB}, {upB, 1'b0, oB, 1'b0, mB});
    check_state("R8");
    chk("R8", "B wins case 1", {30'd0, chan_sel}, 32'h2);
    // give bus to A, then both take in the same cycle
    wr1(1'b0, 8'h01, {upA, 1'b0, oA, 1'b0, mB});
    chk("R8", "A owns before", {30'd0, chan_sel}, 32'h1);
    wr2({upA, 1'b1, ~oB, 1'b1, mA}, {upB, 1'b0, oB, 1'b0, ~mA});
    check_state("R8");
    chk("R8", "B wins case 2", {30'd0, chan_sel}, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_readonly_bits();
    t_b_takes();
    t_a_takes();
    t_no_change();
    t_cmd_decode();
    t_upper();
    t_release();
    t_simultaneous();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule